// File: doc/BRIEF.md
# Time-Multiplexed Tile Execution Core

This block is the sequential engine of one tile in a time-multiplexed processor array used to run word-level circuits. A static list of instructions sits in a program store, one per time slot. While the block is running it steps through the slots and executes one instruction per clock. When it reaches the last programmed slot it wraps to slot 0. One full pass through the list is one emulated user cycle. The core has no branches. Conditional behaviour comes from predicating any instruction on a compare flag or on one of two external control bits.

Operands live in three kinds of local storage. There is a register memory, a scratch memory, and four small receive buffers that neighbouring tiles fill through a write port. A separate word-addressed data memory serves load and store. An input word can be sampled into storage, and any operand can be pushed to an output word with a one-clock valid strobe. Placement of writes and reads within the schedule decides whether a stored value acts as a combinational net or as a user register. If a value is written before it is read in the pass, it acts as a net. If it is read before it is overwritten, it acts as a register. The program store is filled through a configuration port while the core is halted.

Top module: `tile_core`

## Requirements
- R1: After reset `slot` is 0, `io_valid` is 0, `io_out` is 0, the compare flag is 0, and every register and scratch word reads 0.
- R2: While `run` is 1, `slot` advances by one per clock and returns to 0 on the clock after it equals `last_slot`. While `run` is 0, `slot` is 0 on the next clock and stays there, and no instruction executes.
- R3: A configuration write (`cfg_we`) stores `cfg_instr` at `cfg_addr` only while `run` is 0. Writes while running are ignored.
- R4: Instruction word layout: bits [23:20] opcode, [19:18] predicate select, [17:12] destination operand D, [11:6] operand A, [5:0] operand B. Opcode values: 0 NOP, 1 ADD, 2 ADDI, 3 CMP, 4 LOAD, 5 STORE, 6 IOLOAD, 7 IOSTORE. Any other opcode behaves as NOP.
- R5: The 6-bit operand address map is as follows. Addresses 0-15 are register words and 16-31 are scratch words. Addresses 32-47 are the receive buffers, four words each, in the order north, south, east, west. Addresses 48-63 read as 0. Core writes to addresses 32-63 are ignored. Buffer direction d (0..3) is written from `nb_wdata[32d+31:32d]` at entry `nb_waddr[2d+1:2d]` when `nb_we[d]` is 1.
- R6: ADD writes A+B to D. ADDI writes A plus the zero-extended 6-bit B field to D. Both results wrap modulo 2^32.
- R7: CMP sets the compare flag to 1 when operand A differs from operand B and to 0 otherwise. No other instruction changes the flag.
- R8: Predicate select values: 0 always, 1 compare flag, 2 `ctrl_bits[0]`, 3 `ctrl_bits[1]`. An instruction whose predicate is 0 changes no storage, flag or output.
- R9: STORE writes operand A to data-memory word (value of D) mod 2048. LOAD writes data-memory word (value of B) mod 2048 to D.
- R10: IOLOAD writes `io_in` to D. IOSTORE drives operand A on `io_out` with `io_valid` high for exactly the clock after its slot executes. `io_out` holds its value otherwise.
- R11: A write made in a slot is seen by every later slot. A read in the same slot as a write sees the old value. Within a pass, a value written before it is read therefore acts as a net, and a value read before it is written carries the previous pass's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 executes the schedule, 0 halts at slot 0 |
| last_slot | input | 5 | Index of the final slot of a pass |
| cfg_we | input | 1 | Program store write strobe, honoured only while halted |
| cfg_addr | input | 5 | Slot index to write |
| cfg_instr | input | 24 | Instruction word to write |
| ctrl_bits | input | 2 | External 1-bit control predicates |
| nb_we | input | 4 | Receive buffer write enables, one per direction |
| nb_waddr | input | 8 | Receive buffer entry per direction, 2 bits each |
| nb_wdata | input | 128 | Receive buffer data per direction, 32 bits each |
| io_in | input | 32 | Word sampled by IOLOAD |
| io_out | output | 32 | Word driven by IOSTORE |
| io_valid | output | 1 | One-clock strobe for a new `io_out` |
| slot | output | 5 | Slot executed on the next clock |

## Verification
The bench targets where a pass wraps and where a halt lands. A core that stopped one slot early or late would drop or repeat an output, and one that kept its slot on halt would restart mid-pass. An accumulator is scheduled read-before-write next to a net scheduled write-before-read. This separates register from wire ordering, and a core with the wrong ordering would emit sums shifted by a pass. FIFO-style predicated stores and increments run under all four control-bit combinations. Compare-gated increments run on zero and non-zero inputs. A wrongly decoded predicate would move the read or write pointers and emit the wrong stored word. Addresses above 2047, writes to the read-only buffers, and program writes while running are each observed at `io_out`.

// File: rtl/tile_core_pkg.sv
// Shared encodings for the tile execution core.
// Assumes a 6-bit operand address space and a fixed four-direction neighbourhood.
package tile_core_pkg;

    localparam int OPW     = 4;
    localparam int PSW     = 2;
    localparam int OAW     = 6;
    localparam int INSTR_W = OPW + PSW + 3 * OAW;
    localparam int NB_DIRS = 4;
    localparam int DIRW    = $clog2(NB_DIRS);

    typedef enum logic [OPW-1:0] {
        OP_NOP     = 4'd0,
        OP_ADD     = 4'd1,
        OP_ADDI    = 4'd2,
        OP_CMP     = 4'd3,
        OP_LOAD    = 4'd4,
        OP_STORE   = 4'd5,
        OP_IOLOAD  = 4'd6,
        OP_IOSTORE = 4'd7
    } tile_op_e;

    typedef enum logic [PSW-1:0] {
        PRED_ALWAYS = 2'd0,
        PRED_FLAG   = 2'd1,
        PRED_CTRL0  = 2'd2,
        PRED_CTRL1  = 2'd3
    } tile_pred_e;

    typedef struct packed {
        logic [OPW-1:0] op;
        logic [PSW-1:0] pred;
        logic [OAW-1:0] dst;
        logic [OAW-1:0] srca;
        logic [OAW-1:0] srcb;
    } tile_instr_t;

endpackage

// File: rtl/tile_prog_store.sv
// Slot-indexed instruction store.
// Written through the configuration port only while the core is halted;
// read combinationally at the current slot. Reset fills every slot with NOP.
module tile_prog_store
    import tile_core_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [INSTR_W-1:0] cfg_instr,
    input  logic [AW-1:0]      rd_addr,
    output tile_instr_t        rd_instr
);

    tile_instr_t prog_q [DEPTH];

    // Accept configuration writes while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                prog_q[i] <= '0;
            end
        end else if (cfg_we && !lock) begin
            prog_q[cfg_addr] <= tile_instr_t'(cfg_instr);
        end
    end

    // Present the instruction of the current slot.
    always_comb begin
        rd_instr = prog_q[rd_addr];
    end

endmodule

// File: rtl/tile_operand_file.sv
// Operand storage: register words, scratch words and four receive buffers
// in one 6-bit address space; addresses past the buffers read as zero.
// Assumes R_WORDS + X_WORDS + 4*NB_WORDS <= 64. Core writes to buffer or
// zero addresses are dropped; the buffers are filled only by the neighbour port.
module tile_operand_file
    import tile_core_pkg::*;
#(
    parameter int DW       = 32,
    parameter int R_WORDS  = 16,
    parameter int X_WORDS  = 16,
    parameter int NB_WORDS = 4,
    parameter int NBAW     = $clog2(NB_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OAW-1:0]          rd_addr_a,
    input  logic [OAW-1:0]          rd_addr_b,
    input  logic [OAW-1:0]          rd_addr_d,
    output logic [DW-1:0]           rd_data_a,
    output logic [DW-1:0]           rd_data_b,
    output logic [DW-1:0]           rd_data_d,
    input  logic                    wr_en,
    input  logic [OAW-1:0]          wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [NB_DIRS-1:0]      nb_we,
    input  logic [NB_DIRS*NBAW-1:0] nb_waddr,
    input  logic [NB_DIRS*DW-1:0]   nb_wdata
);

    localparam int RAW       = $clog2(R_WORDS);
    localparam int XAW       = $clog2(X_WORDS);
    localparam int X_BASE    = R_WORDS;
    localparam int NB_BASE   = R_WORDS + X_WORDS;
    localparam int ZERO_BASE = NB_BASE + NB_DIRS * NB_WORDS;

    logic [DW-1:0] r_q  [R_WORDS];
    logic [DW-1:0] x_q  [X_WORDS];
    logic [DW-1:0] nb_q [NB_DIRS][NB_WORDS];

    logic [OAW-1:0] x_woff;
    logic           r_hit;
    logic           x_hit;

    // Decode an operand address into the storage word it names.
    function automatic logic [DW-1:0] fetch(input logic [OAW-1:0] a);
        logic [OAW-1:0] off;
        fetch = '0;
        off   = '0;
        if (int'(a) < X_BASE) begin
            fetch = r_q[a[RAW-1:0]];
        end else if (int'(a) < NB_BASE) begin
            off   = a - OAW'(X_BASE);
            fetch = x_q[off[XAW-1:0]];
        end else if (int'(a) < ZERO_BASE) begin
            off   = a - OAW'(NB_BASE);
            fetch = nb_q[off[NBAW +: DIRW]][off[NBAW-1:0]];
        end
    endfunction

    // Three combinational read ports.
    always_comb begin
        rd_data_a = fetch(rd_addr_a);
        rd_data_b = fetch(rd_addr_b);
        rd_data_d = fetch(rd_addr_d);
    end

    // Classify the write target.
    always_comb begin
        r_hit  = wr_en && (int'(wr_addr) < X_BASE);
        x_hit  = wr_en && (int'(wr_addr) >= X_BASE) && (int'(wr_addr) < NB_BASE);
        x_woff = wr_addr - OAW'(X_BASE);
    end

    // Register words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < R_WORDS; i++) begin
                r_q[i] <= '0;
            end
        end else if (r_hit) begin
            r_q[wr_addr[RAW-1:0]] <= wr_data;
        end
    end

    // Scratch words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < X_WORDS; i++) begin
                x_q[i] <= '0;
            end
        end else if (x_hit) begin
            x_q[x_woff[XAW-1:0]] <= wr_data;
        end
    end

    // Receive buffers, filled by the neighbour port, one lane per direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NB_DIRS; d++) begin
                for (int k = 0; k < NB_WORDS; k++) begin
                    nb_q[d][k] <= '0;
                end
            end
        end else begin
            for (int d = 0; d < NB_DIRS; d++) begin
                if (nb_we[d]) begin
                    nb_q[d][nb_waddr[d*NBAW +: NBAW]] <= nb_wdata[d*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/tile_data_mem.sv
// User data memory: word-addressed, combinational read, one write per clock.
// Assumes the caller has already reduced addresses to AW bits. No reset.
module tile_data_mem #(
    parameter int DW    = 32,
    parameter int WORDS = 2048,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [WORDS];

    // Commit a store.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Serve a load.
    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/tile_exec.sv
// Single-slot execute stage: evaluates the predicate, computes the ALU result
// and turns the opcode into write enables for operand storage, data memory,
// compare flag and output port. Purely combinational; nothing fires unless run is 1.
module tile_exec
    import tile_core_pkg::*;
#(
    parameter int DW   = 32,
    parameter int DMAW = 11
) (
    input  tile_instr_t    instr,
    input  logic           run,
    input  logic           flag,
    input  logic [1:0]     ctrl_bits,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    input  logic [DW-1:0]  op_d,
    input  logic [DW-1:0]  dm_rdata,
    input  logic [DW-1:0]  io_in,
    output logic           fire,
    output logic           rf_we,
    output logic [OAW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata,
    output logic           dm_we,
    output logic [DMAW-1:0] dm_waddr,
    output logic [DMAW-1:0] dm_raddr,
    output logic [DW-1:0]  dm_wdata,
    output logic           flag_we,
    output logic           flag_d,
    output logic           io_we,
    output logic [DW-1:0]  io_wdata
);

    logic pred_ok;

    // Choose the predicate bit.
    always_comb begin
        case (tile_pred_e'(instr.pred))
            PRED_FLAG:  pred_ok = flag;
            PRED_CTRL0: pred_ok = ctrl_bits[0];
            PRED_CTRL1: pred_ok = ctrl_bits[1];
            default:    pred_ok = 1'b1;
        endcase
        fire = run && pred_ok;
    end

    // Decode the opcode into side effects.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = instr.dst;
        rf_wdata = '0;
        dm_we    = 1'b0;
        dm_waddr = op_d[DMAW-1:0];
        dm_raddr = op_b[DMAW-1:0];
        dm_wdata = op_a;
        flag_we  = 1'b0;
        flag_d   = (op_a != op_b);
        io_we    = 1'b0;
        io_wdata = op_a;
        if (fire) begin
            case (instr.op)
                OP_ADD: begin
                    rf_we    = 1'b1;
                    rf_wdata = op_a + op_b;
                end
                OP_ADDI: begin
                    rf_we    = 1'b1;
                    rf_wdata = op_a + DW'(instr.srcb);
                end
                OP_CMP:     flag_we = 1'b1;
                OP_LOAD: begin
                    rf_we    = 1'b1;
                    rf_wdata = dm_rdata;
                end
                OP_STORE:   dm_we = 1'b1;
                OP_IOLOAD: begin
                    rf_we    = 1'b1;
                    rf_wdata = io_in;
                end
                OP_IOSTORE: io_we = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tile_core.sv
// Time-multiplexed tile core: steps a static slot schedule, one instruction
// per clock, wrapping after last_slot; one pass is one emulated user cycle.
// Assumes last_slot and the program are set while halted. Halting returns to slot 0.
module tile_core
    import tile_core_pkg::*;
#(
    parameter int DW         = 32,
    parameter int PROG_DEPTH = 32,
    parameter int R_WORDS    = 16,
    parameter int X_WORDS    = 16,
    parameter int NB_WORDS   = 4,
    parameter int DM_WORDS   = 2048,
    parameter int PAW        = $clog2(PROG_DEPTH),
    parameter int NBAW       = $clog2(NB_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [PAW-1:0]          last_slot,
    input  logic                    cfg_we,
    input  logic [PAW-1:0]          cfg_addr,
    input  logic [INSTR_W-1:0]      cfg_instr,
    input  logic [1:0]              ctrl_bits,
    input  logic [NB_DIRS-1:0]      nb_we,
    input  logic [NB_DIRS*NBAW-1:0] nb_waddr,
    input  logic [NB_DIRS*DW-1:0]   nb_wdata,
    input  logic [DW-1:0]           io_in,
    output logic [DW-1:0]           io_out,
    output logic                    io_valid,
    output logic [PAW-1:0]          slot
);

    localparam int DMAW = $clog2(DM_WORDS);

    tile_instr_t     cur_instr;
    logic [DW-1:0]   op_a, op_b, op_d, dm_rdata;
    logic            exec_fire;
    logic            rf_we, dm_we, flag_we, flag_d, io_we;
    logic [OAW-1:0]  rf_waddr;
    logic [DW-1:0]   rf_wdata, dm_wdata, io_wdata;
    logic [DMAW-1:0] dm_waddr, dm_raddr;
    logic            flag_q;

    tile_prog_store #(.DEPTH(PROG_DEPTH), .AW(PAW)) i_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (run),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_instr(cfg_instr),
        .rd_addr  (slot),
        .rd_instr (cur_instr)
    );

    tile_operand_file #(
        .DW(DW), .R_WORDS(R_WORDS), .X_WORDS(X_WORDS),
        .NB_WORDS(NB_WORDS), .NBAW(NBAW)
    ) i_opf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr_a(cur_instr.srca),
        .rd_addr_b(cur_instr.srcb),
        .rd_addr_d(cur_instr.dst),
        .rd_data_a(op_a),
        .rd_data_b(op_b),
        .rd_data_d(op_d),
        .wr_en    (rf_we),
        .wr_addr  (rf_waddr),
        .wr_data  (rf_wdata),
        .nb_we    (nb_we),
        .nb_waddr (nb_waddr),
        .nb_wdata (nb_wdata)
    );

    tile_data_mem #(.DW(DW), .WORDS(DM_WORDS), .AW(DMAW)) i_dmem (
        .clk  (clk),
        .we   (dm_we),
        .waddr(dm_waddr),
        .wdata(dm_wdata),
        .raddr(dm_raddr),
        .rdata(dm_rdata)
    );

    tile_exec #(.DW(DW), .DMAW(DMAW)) i_exec (
        .instr    (cur_instr),
        .run      (run),
        .flag     (flag_q),
        .ctrl_bits(ctrl_bits),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_d     (op_d),
        .dm_rdata (dm_rdata),
        .io_in    (io_in),
        .fire     (exec_fire),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .dm_we    (dm_we),
        .dm_waddr (dm_waddr),
        .dm_raddr (dm_raddr),
        .dm_wdata (dm_wdata),
        .flag_we  (flag_we),
        .flag_d   (flag_d),
        .io_we    (io_we),
        .io_wdata (io_wdata)
    );

    // Slot sequencer: step, wrap after the last slot, park at 0 when halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot <= '0;
        end else if (slot == last_slot) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // Compare flag used as a predicate by later slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (flag_we) begin
            flag_q <= flag_d;
        end
    end

    // Output word and its one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_out   <= '0;
            io_valid <= 1'b0;
        end else begin
            io_valid <= io_we;
            if (io_we) begin
                io_out <= io_wdata;
            end
        end
    end

endmodule

// File: rtl/tile_core_chk.sv
// Protocol checker for tile_core, bound into every instance.
module tile_core_chk #(
    parameter int DW  = 32,
    parameter int PAW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic [PAW-1:0] last_slot,
    input logic [PAW-1:0] slot,
    input logic           io_valid,
    input logic [DW-1:0]  io_out,
    input logic           io_we,
    input logic           flag_we,
    input logic           flag_q
);

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot == last_slot) |=> (slot == '0));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot != last_slot) |=> (slot == $past(slot) + 1'b1));

    // R2
    halt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (slot == '0));

    // R10
    io_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> $past(io_we));

    // R10
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |-> $stable(io_out));

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_q) |-> $past(flag_we));

endmodule

bind tile_core tile_core_chk #(.DW(DW), .PAW(PAW)) i_tile_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .last_slot(last_slot),
    .slot     (slot),
    .io_valid (io_valid),
    .io_out   (io_out),
    .io_we    (io_we),
    .flag_we  (flag_we),
    .flag_q   (flag_q)
);

// File: tb/test_tile_core.sv
// Directed bench for tile_core: one task per scenario, each checks its outputs.
module test_tile_core;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         run;
    logic [4:0]   last_slot;
    logic         cfg_we;
    logic [4:0]   cfg_addr;
    logic [23:0]  cfg_instr;
    logic [1:0]   ctrl_bits;
    logic [3:0]   nb_we;
    logic [7:0]   nb_waddr;
    logic [127:0] nb_wdata;
    logic [31:0]  io_in;
    logic [31:0]  io_out;
    logic         io_valid;
    logic [4:0]   slot;

    int checks = 0;
    int errors = 0;
    logic [31:0] out_buf [16];
    int n_out;
    logic [31:0] in_vec [8];
    logic [1:0]  ctrl_vec [8];
    bit finished = 0;

    // operand addresses
    localparam logic [5:0] ZR = 6'd48;
    localparam logic [5:0] X3 = 6'd19;
    localparam logic [5:0] E2 = 6'd42;

    tile_core i_tile_core (
        .clk(clk), .rst_n(rst_n), .run(run), .last_slot(last_slot),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_instr(cfg_instr),
        .ctrl_bits(ctrl_bits), .nb_we(nb_we), .nb_waddr(nb_waddr),
        .nb_wdata(nb_wdata), .io_in(io_in), .io_out(io_out),
        .io_valid(io_valid), .slot(slot)
    );

    always #5 clk = ~clk;

    function automatic logic [23:0] mk(input int op, input int pr, input int d,
                                       input int a, input int b);
        return {4'(op), 2'(pr), 6'(d), 6'(a), 6'(b)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; run = 0; last_slot = 0; cfg_we = 0; cfg_addr = 0;
        cfg_instr = 0; ctrl_bits = 0; nb_we = 0; nb_waddr = 0; nb_wdata = 0;
        io_in = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        n_out = 0;
    endtask

    task automatic load(input int addr, input logic [23:0] ins);
        cfg_we = 1; cfg_addr = 5'(addr); cfg_instr = ins;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic run_user(input int n_user, input int last);
        last_slot = 5'(last);
        for (int u = 0; u < n_user; u++) begin
            io_in = in_vec[u]; ctrl_bits = ctrl_vec[u]; run = 1;
            for (int s = 0; s <= last; s++) begin
                @(negedge clk);
                if (io_valid && n_out < 16) begin
                    out_buf[n_out] = io_out;
                    n_out++;
                end
            end
        end
        run = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 slot", 32'(slot), 0);
        check("R1 io_valid", 32'(io_valid), 0);
        check("R1 io_out", io_out, 0);
    endtask

    task automatic t_arith();
        do_reset();
        load(0, mk(6, 0, 1, 0, 0));        // IOLOAD R1
        load(1, mk(2, 0, 2, 1, 5));        // ADDI R2,R1,5
        load(2, mk(1, 0, 3, 2, 1));        // ADD R3,R2,R1
        load(3, mk(7, 0, 0, 3, 0));        // IOSTORE R3
        in_vec[0] = 32'hFFFF_FFF0; ctrl_vec[0] = 0;
        run_user(1, 3);
        check("R6 output count", 32'(n_out), 1);
        check("R6 wrap sum", out_buf[0], 32'hFFFF_FFE5);
        check("R2 slot after wrap", 32'(slot), 0);
    endtask

    task automatic t_reg_wire();
        do_reset();
        load(0, mk(6, 0, 1, 0, 0));        // IOLOAD R1 (net)
        load(1, mk(7, 0, 0, 5, 0));        // IOSTORE R5 (register read first)
        load(2, mk(1, 0, 5, 5, 1));        // ADD R5,R5,R1
        in_vec[0] = 10; in_vec[1] = 20; in_vec[2] = 30;
        ctrl_vec[0] = 0; ctrl_vec[1] = 0; ctrl_vec[2] = 0;
        run_user(3, 2);
        check("R11 count", 32'(n_out), 3);
        check("R11 pass1 old reg", out_buf[0], 0);
        check("R11 pass2", out_buf[1], 10);
        check("R11 pass3", out_buf[2], 30);
    endtask

    task automatic t_fifo();
        do_reset();
        load(0, mk(6, 0, 1, 0, 0));        // IOLOAD R1
        load(1, mk(5, 2, 2, 1, 0));        // STORE.c0 [R2],R1
        load(2, mk(2, 2, 2, 2, 1));        // ADDI.c0 R2,R2,1
        load(3, mk(4, 0, 3, 0, 4));        // LOAD R3,[R4]
        load(4, mk(7, 0, 0, 3, 0));        // IOSTORE R3
        load(5, mk(2, 3, 4, 4, 1));        // ADDI.c1 R4,R4,1
        in_vec[0] = 111; ctrl_vec[0] = 2'b01;
        in_vec[1] = 222; ctrl_vec[1] = 2'b00;
        in_vec[2] = 333; ctrl_vec[2] = 2'b11;
        in_vec[3] = 444; ctrl_vec[3] = 2'b10;
        run_user(4, 5);
        check("R8 count", 32'(n_out), 4);
        check("R8 R9 ctrl0 store", out_buf[0], 111);
        check("R8 ctrl low no write", out_buf[1], 111);
        check("R8 ctrl1 pointer hold", out_buf[2], 111);
        check("R8 R9 ctrl1 advance", out_buf[3], 333);
    endtask

    task automatic t_cmp();
        do_reset();
        load(0, mk(6, 0, 1, 0, 0));        // IOLOAD R1
        load(1, mk(3, 0, 0, 1, ZR));       // CMP R1,zero
        load(2, mk(2, 1, 6, 6, 1));        // ADDI.flag R6,R6,1
        load(3, mk(7, 0, 0, 6, 0));        // IOSTORE R6
        in_vec[0] = 0; in_vec[1] = 7; in_vec[2] = 0; in_vec[3] = 9;
        for (int i = 0; i < 4; i++) ctrl_vec[i] = 0;
        run_user(4, 3);
        check("R7 count", 32'(n_out), 4);
        check("R7 equal no inc", out_buf[0], 0);
        check("R7 differ inc", out_buf[1], 1);
        check("R7 flag cleared", out_buf[2], 1);
        check("R7 differ again", out_buf[3], 2);
    endtask

    task automatic t_mem_map();
        do_reset();
        nb_we = 4'b0100; nb_waddr = 8'b0010_0000;
        nb_wdata = 128'h0; nb_wdata[95:64] = 32'h0000_1234;
        @(negedge clk);
        nb_we = 0;
        load(0, mk(6, 0, 7, 0, 0));        // IOLOAD R7
        load(1, mk(1, 0, X3, E2, ZR));     // ADD X3,E2,zero
        load(2, mk(5, 0, 7, X3, 0));       // STORE [R7],X3
        load(3, mk(2, 0, 9, ZR, 5));       // ADDI R9,zero,5
        load(4, mk(4, 0, 8, 0, 9));        // LOAD R8,[R9]
        load(5, mk(7, 0, 0, 8, 0));        // IOSTORE R8
        load(6, mk(2, 0, E2, ZR, 1));      // ADDI E2,zero,1 (dropped)
        load(7, mk(7, 0, 0, E2, 0));       // IOSTORE E2
        in_vec[0] = 32'h805; ctrl_vec[0] = 0;
        run_user(1, 7);
        check("R5 count", 32'(n_out), 2);
        check("R5 R9 buffer via scratch and wrapped address", out_buf[0], 32'h1234);
        check("R5 buffer write ignored", out_buf[1], 32'h1234);
    endtask

    task automatic t_cfg_halt();
        do_reset();
        load(0, mk(2, 0, 1, ZR, 9));       // ADDI R1,zero,9
        load(1, mk(7, 0, 0, 1, 0));        // IOSTORE R1
        last_slot = 1; ctrl_bits = 0; io_in = 0;
        run = 1; cfg_we = 1; cfg_addr = 1; cfg_instr = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_we = 0;
            if (io_valid && n_out < 16) begin out_buf[n_out] = io_out; n_out++; end
        end
        check("R3 write while running ignored", 32'(n_out), 2);
        check("R10 value", out_buf[0], 9);
        @(negedge clk);
        check("R2 step", 32'(slot), 1);
        run = 0;
        @(negedge clk);
        check("R2 halt parks", 32'(slot), 0);
        check("R8 R2 halted no exec", 32'(io_valid), 0);
        repeat (3) @(negedge clk);
        check("R2 halt holds", 32'(slot), 0);
        load(1, 24'h0);                    // NOP at slot 1 while halted
        n_out = 0; in_vec[0] = 0; ctrl_vec[0] = 0;
        run_user(2, 1);
        check("R3 halted write taken", 32'(n_out), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; run = 0;
        t_reset();
        t_arith();
        t_reg_wire();
        t_fifo();
        t_cmp();
        t_mem_map();
        t_cfg_halt();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule